// File: doc/BRIEF.md
# Framebuffer Fetch and Palette Sequencer

This block is the control engine that starts every frame fetch of an LCD controller. When software raises the enable control, the sequencer first checks that the framebuffer bounds are valid. Unless the loading mode is data-only, it then reads the 512-byte palette header from buffer 0 and reports when the palette has loaded. After that it waits in an armed state for a frame-start strobe from the panel timing logic.

On each strobe it may reload the header. It decodes the colour depth from bits inside the first palette word and derives where the pixel data starts. It checks that the frame fits in the buffer, hands the frame over by setting a DMA condition bit, and then issues one read request per display line over a valid/ready handshake. In dual-buffer mode, successive frames alternate between two buffers. A subpanel setting can turn the line number into either a first line or a line limit.

The outputs are memory read requests, the depth and line-range information needed by the pixel path, and single-cycle status and condition pulses for the register and interrupt logic.

Top module: `fbfetch_seq`

## Requirements
- R1: On a rising edge of `enable_i`, if `bound_ok_i[0]` or `bound_ok_i[1]` is low, or if `dual_i` is set and `bound_ok_i[2]` or `bound_ok_i[3]` is low, the block pulses `dma_cond_o[2]`. It pulses `dma_irq_o` too when `dma_mask_i[1]` is set. It issues no read and drops `active_o`. Bits 3:2 have no effect when `dual_i` is clear.
- R2: After enable passes the bounds check with `load_mode_i` other than 2, the block issues exactly one header read: address `buf0_top_i`, `rd_len_o` = 512, `rd_hdr_o` = 1. When `pal_valid_i` delivers the first palette word, `pal_done_o` pulses once. With mode 2 there is no header read.
- R3: A frame-start strobe while armed does the following, depending on `load_mode_i`. Mode 1 issues nothing. Modes 0 and 3 read the header at the current buffer top and then fetch lines. Mode 2 fetches lines at once, using the palette word held from the last header read.
- R4: Depth code = palette word bits 14:12. Code 1 gives 2 bpp, 2 gives 4 bpp, 3 gives 8 bpp, and 4 to 7 give 16 bpp, shown on `pix_bpp_o`. `pix_12bit_o` is set for 16 bpp when `tft_i` is clear. Code 0 skips the frame: no line reads and no condition pulse.
- R5: Pixel data starts at buffer top plus an offset. The offset is 0x200 for codes 3 to 7 and 0x20 for codes 1 and 2 when a header is read, and 0 in mode 2.
- R6: If offset + width×height×bpp/8 is greater than (bottom − top) + 2 for the current buffer, the block pulses `sync_err_o`, drops `active_o` and fetches no lines. Equality passes.
- R7: When a frame is accepted, `dma_cond_o[i]` pulses for the current buffer index i, and `dma_irq_o` pulses when `dma_mask_i[0]` is set. In dual mode the index then toggles.
- R8: Line reads have address = data start + line×stride and `rd_len_o` = stride = width×bpp/8, with `rd_hdr_o` = 0. There is one read per line, in ascending order. Address and valid hold until `rd_ready_i` is seen.
- R9: With `sub_en_i` set, `sub_line_i` is the first line when `sub_first_i` is 1, and the line count when it is 0. Otherwise lines 0 to height−1 are fetched. `line_first_o`/`line_end_o` give the range, with the end exclusive.
- R10: When `enable_i` falls while active, the request drops on the next cycle. `off_done_o` pulses if the mode is not 1. A later enable restarts at buffer 0 and reloads the header. A fall while inactive gives no pulse.
- R11: A frame-start strobe that arrives while a frame is being fetched is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable_i | input | 1 | Controller enable level |
| load_mode_i | input | 2 | 0/3 header+data, 1 palette only, 2 data only |
| tft_i | input | 1 | Active-matrix panel; clear selects 12-bit colour at 16 bpp |
| dual_i | input | 1 | Alternate between two buffers |
| width_m1_i | input | LW | Width in pixels minus one |
| height_m1_i | input | LW | Height in lines minus one |
| sub_en_i | input | 1 | Subpanel line field in use |
| sub_first_i | input | 1 | 1: field is first line, 0: line count |
| sub_line_i | input | LW | Subpanel line number |
| buf0_top_i | input | AW | Buffer 0 start address |
| buf0_bot_i | input | AW | Buffer 0 end address |
| buf1_top_i | input | AW | Buffer 1 start address |
| buf1_bot_i | input | AW | Buffer 1 end address |
| bound_ok_i | input | 4 | Validity of buf0 top/bot, buf1 top/bot (bits 0..3) |
| dma_mask_i | input | 2 | Bit 0 frame interrupt, bit 1 bounds-error interrupt |
| frame_start_i | input | 1 | Frame-start strobe from panel timing |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read start address |
| rd_len_o | output | LW+3 | Read length in bytes |
| rd_hdr_o | output | 1 | Request is the palette header |
| pal_valid_i | input | 1 | First palette word returned |
| pal_word_i | input | 16 | First palette word |
| active_o | output | 1 | Sequencer enabled |
| pix_bpp_o | output | 5 | Bits per pixel of current frame |
| pix_12bit_o | output | 1 | 12-bit colour interpretation |
| line_first_o | output | LW | First fetched line |
| line_end_o | output | LW+1 | Line after the last fetched one |
| stride_o | output | LW+3 | Bytes per line |
| pal_done_o | output | 1 | Palette loaded pulse |
| sync_err_o | output | 1 | Frame size error pulse |
| off_done_o | output | 1 | Disable frame-done pulse |
| dma_cond_o | output | 3 | DMA condition set pulses |
| dma_irq_o | output | 1 | DMA interrupt pulse |

## Verification
Frames are run with depth codes 1, 3 and 5 and with code 0. This separates the two header offsets, three strides and the 12-bit flag, and shows that an unsupported code fetches nothing. The same buffer is also read in all three load modes, which tells a header-then-data frame apart from a data-only frame and from a frame that does nothing. A buffer exactly one byte too small, next to one that just fits, separates the `>` size bound from an off-by-one. Dual frames, subpanel first/count settings, a strobe sent while requests stall, and a disable in the middle of a request tell apart buffer alternation, range selection, strobe blocking and restart at buffer 0.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BCHK,
        ST_PREQ,
        ST_PWAIT,
        ST_WAIT,
        ST_SIZE,
        ST_LINE
    } fbs_state_e;

    localparam logic [1:0] MODE_PAL_ONLY  = 2'd1;
    localparam logic [1:0] MODE_DATA_ONLY = 2'd2;

    localparam int          HDR_BYTES  = 512;
    localparam logic [9:0]  OFF_LONG   = 10'h200;
    localparam logic [9:0]  OFF_SHORT  = 10'h020;
    localparam logic [2:0]  LOG2_WIDE  = 3'd4;

endpackage

// File: rtl/fbs_depth_dec.sv
module fbs_depth_dec
    import fbs_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       tft_i,
    input  logic       data_only_i,
    output logic       ok_o,
    output logic [2:0] bpp_log2_o,
    output logic [4:0] bpp_o,
    output logic       color12_o,
    output logic [9:0] hdr_off_o
);
    always_comb begin
        ok_o = 1'b1;
        unique case (code_i)
            3'd0:    begin bpp_log2_o = 3'd0; ok_o = 1'b0; end
            3'd1:    bpp_log2_o = 3'd1;
            3'd2:    bpp_log2_o = 3'd2;
            3'd3:    bpp_log2_o = 3'd3;
            default: bpp_log2_o = LOG2_WIDE;
        endcase
        bpp_o     = 5'd1 << bpp_log2_o;
        color12_o = (bpp_log2_o == LOG2_WIDE) && !tft_i;
        if (data_only_i)
            hdr_off_o = '0;
        else if (code_i >= 3'd3)
            hdr_off_o = OFF_LONG;
        else
            hdr_off_o = OFF_SHORT;
    end
endmodule

// File: rtl/fbs_size_chk.sv
module fbs_size_chk #(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input  logic [LW-1:0] w_m1_i,
    input  logic [LW-1:0] h_m1_i,
    input  logic [2:0]    bpp_log2_i,
    input  logic [9:0]    hdr_off_i,
    input  logic [AW-1:0] top_i,
    input  logic [AW-1:0] bot_i,
    output logic          fits_o,
    output logic [LW+2:0] stride_o
);
    localparam int PW = 2 * (LW + 1);
    localparam int BW = PW + 4;
    localparam int CW = ((BW + 2 > AW) ? BW + 2 : AW) + 2;

    logic [LW:0]   w, h;
    logic [PW-1:0] prod;
    logic [BW-1:0] bits, bytes;
    logic [CW-1:0] need, limit;
    logic [AW-1:0] span;
    logic [LW+4:0] sbits;

    always_comb begin
        w      = {1'b0, w_m1_i} + (LW+1)'(1);
        h      = {1'b0, h_m1_i} + (LW+1)'(1);
        prod   = PW'(w) * PW'(h);
        bits   = {4'b0, prod} << bpp_log2_i;
        bytes  = bits >> 3;
        need   = CW'(bytes) + CW'(hdr_off_i);
        span   = bot_i - top_i;
        limit  = CW'(span) + CW'(2);
        fits_o = (need <= limit);
        sbits  = {4'b0, w} << bpp_log2_i;
        stride_o = (LW+3)'(sbits >> 3);
    end
endmodule

// File: rtl/fbs_range.sv
module fbs_range #(
    parameter int LW = 10
) (
    input  logic          sub_en_i,
    input  logic          sub_first_i,
    input  logic [LW-1:0] sub_line_i,
    input  logic [LW-1:0] h_m1_i,
    output logic [LW-1:0] first_o,
    output logic [LW:0]   end_o,
    output logic          any_o
);
    always_comb begin
        first_o = (sub_en_i && sub_first_i) ? sub_line_i : '0;
        if (sub_en_i && !sub_first_i)
            end_o = {1'b0, sub_line_i};
        else
            end_o = {1'b0, h_m1_i} + (LW+1)'(1);
        any_o = ({1'b0, first_o} < end_o);
    end
endmodule

// File: rtl/fbfetch_seq.sv
module fbfetch_seq
    import fbs_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic [1:0]    load_mode_i,
    input  logic          tft_i,
    input  logic          dual_i,
    input  logic [LW-1:0] width_m1_i,
    input  logic [LW-1:0] height_m1_i,
    input  logic          sub_en_i,
    input  logic          sub_first_i,
    input  logic [LW-1:0] sub_line_i,
    input  logic [AW-1:0] buf0_top_i,
    input  logic [AW-1:0] buf0_bot_i,
    input  logic [AW-1:0] buf1_top_i,
    input  logic [AW-1:0] buf1_bot_i,
    input  logic [3:0]    bound_ok_i,
    input  logic [1:0]    dma_mask_i,
    input  logic          frame_start_i,
    output logic          rd_valid_o,
    input  logic          rd_ready_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [LW+2:0] rd_len_o,
    output logic          rd_hdr_o,
    input  logic          pal_valid_i,
    input  logic [15:0]   pal_word_i,
    output logic          active_o,
    output logic [4:0]    pix_bpp_o,
    output logic          pix_12bit_o,
    output logic [LW-1:0] line_first_o,
    output logic [LW:0]   line_end_o,
    output logic [LW+2:0] stride_o,
    output logic          pal_done_o,
    output logic          sync_err_o,
    output logic          off_done_o,
    output logic [2:0]    dma_cond_o,
    output logic          dma_irq_o
);
    localparam int LEN_W = LW + 3;

    typedef struct packed {
        fbs_state_e      st;
        logic            en_prev;
        logic            init;
        logic            cur;
        logic [15:0]     pal_word;
        logic            rd_valid;
        logic [AW-1:0]   rd_addr;
        logic [LEN_W-1:0] rd_len;
        logic            rd_hdr;
        logic [LW:0]     line;
        logic [LW:0]     line_end;
        logic [LW-1:0]   line_first;
        logic [LEN_W-1:0] stride;
        logic [4:0]      bpp;
        logic            c12;
        logic            pal_done;
        logic            sync_err;
        logic            off_done;
        logic [2:0]      cond;
        logic            irq;
    } seq_t;

    seq_t seq_d, seq_q;

    // current buffer selection
    logic [AW-1:0] top_sel, bot_sel;
    logic          bounds_bad;

    // decode of held palette word
    logic          dec_ok, dec_c12;
    logic [2:0]    dec_log2;
    logic [4:0]    dec_bpp;
    logic [9:0]    dec_off;
    logic          fits;
    logic [LEN_W-1:0] stride_w;
    logic [LW-1:0] rng_first;
    logic [LW:0]   rng_end;
    logic          rng_any;
    logic [AW-1:0] start_addr;

    assign top_sel    = seq_q.cur ? buf1_top_i : buf0_top_i;
    assign bot_sel    = seq_q.cur ? buf1_bot_i : buf0_bot_i;
    assign bounds_bad = !bound_ok_i[0] || !bound_ok_i[1] ||
                        (dual_i && (!bound_ok_i[2] || !bound_ok_i[3]));

    fbs_depth_dec u_dec (
        .code_i      (seq_q.pal_word[14:12]),
        .tft_i       (tft_i),
        .data_only_i (load_mode_i == MODE_DATA_ONLY),
        .ok_o        (dec_ok),
        .bpp_log2_o  (dec_log2),
        .bpp_o       (dec_bpp),
        .color12_o   (dec_c12),
        .hdr_off_o   (dec_off)
    );

    fbs_size_chk #(.AW(AW), .LW(LW)) u_size (
        .w_m1_i     (width_m1_i),
        .h_m1_i     (height_m1_i),
        .bpp_log2_i (dec_log2),
        .hdr_off_i  (dec_off),
        .top_i      (top_sel),
        .bot_i      (bot_sel),
        .fits_o     (fits),
        .stride_o   (stride_w)
    );

    fbs_range #(.LW(LW)) u_range (
        .sub_en_i    (sub_en_i),
        .sub_first_i (sub_first_i),
        .sub_line_i  (sub_line_i),
        .h_m1_i      (height_m1_i),
        .first_o     (rng_first),
        .end_o       (rng_end),
        .any_o       (rng_any)
    );

    assign start_addr = top_sel + AW'(dec_off) + (AW'(rng_first) * AW'(stride_w));

    always_comb begin
        seq_d          = seq_q;
        seq_d.en_prev  = enable_i;
        seq_d.pal_done = 1'b0;
        seq_d.sync_err = 1'b0;
        seq_d.off_done = 1'b0;
        seq_d.cond     = '0;
        seq_d.irq      = 1'b0;

        unique case (seq_q.st)
            ST_OFF: begin
                if (enable_i && !seq_q.en_prev)
                    seq_d.st = ST_BCHK;
            end
            ST_BCHK: begin
                seq_d.cur = 1'b0;
                if (bounds_bad) begin                 // R1
                    seq_d.cond[2] = 1'b1;
                    seq_d.irq     = dma_mask_i[1];
                    seq_d.st      = ST_OFF;
                end else if (load_mode_i != MODE_DATA_ONLY) begin   // R2
                    seq_d.init     = 1'b1;
                    seq_d.rd_valid = 1'b1;
                    seq_d.rd_addr  = buf0_top_i;
                    seq_d.rd_len   = LEN_W'(HDR_BYTES);
                    seq_d.rd_hdr   = 1'b1;
                    seq_d.st       = ST_PREQ;
                end else begin
                    seq_d.st = ST_WAIT;
                end
            end
            ST_PREQ: begin
                if (rd_ready_i) begin
                    seq_d.rd_valid = 1'b0;
                    seq_d.st       = ST_PWAIT;
                end
            end
            ST_PWAIT: begin
                if (pal_valid_i) begin
                    seq_d.pal_word = pal_word_i;
                    if (seq_q.init) begin
                        seq_d.init     = 1'b0;
                        seq_d.pal_done = 1'b1;
                        seq_d.st       = ST_WAIT;
                    end else begin
                        seq_d.st = ST_SIZE;
                    end
                end
            end
            ST_WAIT: begin
                if (frame_start_i) begin                  // R3
                    if (load_mode_i == MODE_PAL_ONLY) begin
                        seq_d.st = ST_WAIT;
                    end else if (load_mode_i == MODE_DATA_ONLY) begin
                        seq_d.st = ST_SIZE;
                    end else begin
                        seq_d.rd_valid = 1'b1;
                        seq_d.rd_addr  = top_sel;
                        seq_d.rd_len   = LEN_W'(HDR_BYTES);
                        seq_d.rd_hdr   = 1'b1;
                        seq_d.st       = ST_PREQ;
                    end
                end
            end
            ST_SIZE: begin
                if (!dec_ok) begin                        // R4
                    seq_d.st = ST_WAIT;
                end else if (!fits) begin                 // R6
                    seq_d.sync_err = 1'b1;
                    seq_d.cur      = 1'b0;
                    seq_d.st       = ST_OFF;
                end else begin                            // R7
                    seq_d.cond[seq_q.cur] = 1'b1;
                    seq_d.irq        = dma_mask_i[0];
                    seq_d.cur        = dual_i ? !seq_q.cur : seq_q.cur;
                    seq_d.bpp        = dec_bpp;
                    seq_d.c12        = dec_c12;
                    seq_d.stride     = stride_w;
                    seq_d.line_first = rng_first;
                    seq_d.line_end   = rng_end;
                    seq_d.line       = {1'b0, rng_first};
                    seq_d.rd_addr    = start_addr;
                    seq_d.rd_len     = stride_w;
                    seq_d.rd_hdr     = 1'b0;
                    seq_d.rd_valid   = rng_any;           // R9
                    seq_d.st         = rng_any ? ST_LINE : ST_WAIT;
                end
            end
            ST_LINE: begin
                if (rd_ready_i) begin                     // R8
                    if (seq_q.line + (LW+1)'(1) == seq_q.line_end) begin
                        seq_d.rd_valid = 1'b0;
                        seq_d.st       = ST_WAIT;
                    end else begin
                        seq_d.line    = seq_q.line + (LW+1)'(1);
                        seq_d.rd_addr = seq_q.rd_addr + AW'(seq_q.stride);
                    end
                end
            end
            default: seq_d.st = ST_OFF;
        endcase

        if (!enable_i && seq_q.st != ST_OFF) begin        // R10
            seq_d          = seq_q;
            seq_d.en_prev  = 1'b0;
            seq_d.st       = ST_OFF;
            seq_d.rd_valid = 1'b0;
            seq_d.cur      = 1'b0;
            seq_d.init     = 1'b0;
            seq_d.pal_done = 1'b0;
            seq_d.sync_err = 1'b0;
            seq_d.cond     = '0;
            seq_d.irq      = 1'b0;
            seq_d.off_done = (load_mode_i != MODE_PAL_ONLY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_OFF;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_valid_o   = seq_q.rd_valid;
    assign rd_addr_o    = seq_q.rd_addr;
    assign rd_len_o     = seq_q.rd_len;
    assign rd_hdr_o     = seq_q.rd_hdr;
    assign active_o     = (seq_q.st != ST_OFF);
    assign pix_bpp_o    = seq_q.bpp;
    assign pix_12bit_o  = seq_q.c12;
    assign line_first_o = seq_q.line_first;
    assign line_end_o   = seq_q.line_end;
    assign stride_o     = seq_q.stride;
    assign pal_done_o   = seq_q.pal_done;
    assign sync_err_o   = seq_q.sync_err;
    assign off_done_o   = seq_q.off_done;
    assign dma_cond_o   = seq_q.cond;
    assign dma_irq_o    = seq_q.irq;

endmodule

// File: rtl/fbfetch_seq_chk.sv
module fbfetch_seq_chk #(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable_i,
    input logic          rd_valid_o,
    input logic          rd_ready_i,
    input logic [AW-1:0] rd_addr_o,
    input logic          rd_hdr_o,
    input logic          active_o,
    input logic [LW-1:0] line_first_o,
    input logic [LW:0]   line_end_o,
    input logic          sync_err_o,
    input logic [2:0]    dma_cond_o,
    input logic          dma_irq_o
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i && enable_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !rd_valid_o); // R10

    AST_SYNC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> (!active_o && !rd_valid_o)); // R6

    AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dma_cond_o)); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq_o |-> (dma_cond_o != 3'b000)); // R1

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_hdr_o) |-> ({1'b0, line_first_o} < line_end_o)); // R9
endmodule

bind fbfetch_seq fbfetch_seq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .rd_valid_o   (rd_valid_o),
    .rd_ready_i   (rd_ready_i),
    .rd_addr_o    (rd_addr_o),
    .rd_hdr_o     (rd_hdr_o),
    .active_o     (active_o),
    .line_first_o (line_first_o),
    .line_end_o   (line_end_o),
    .sync_err_o   (sync_err_o),
    .dma_cond_o   (dma_cond_o),
    .dma_irq_o    (dma_irq_o)
);

// File: tb/fbfetch_seq_test.sv
module fbfetch_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          enable_i = 0, tft_i = 1, dual_i = 0;
    logic [1:0]    load_mode_i = 0, dma_mask_i = 2'b11;
    logic [LW-1:0] width_m1_i = 10'd7, height_m1_i = 10'd3, sub_line_i = 0;
    logic          sub_en_i = 0, sub_first_i = 0, frame_start_i = 0;
    logic [AW-1:0] buf0_top_i = 32'h1000, buf0_bot_i = 32'h2000;
    logic [AW-1:0] buf1_top_i = 32'h8000, buf1_bot_i = 32'h9000;
    logic [3:0]    bound_ok_i = 4'b1111;
    logic          rd_ready_i = 0, pal_valid_i = 0;
    logic [15:0]   pal_word_i = 16'h3000;
    logic          rd_valid_o, rd_hdr_o, active_o, pix_12bit_o;
    logic [AW-1:0] rd_addr_o;
    logic [LW+2:0] rd_len_o, stride_o;
    logic [4:0]    pix_bpp_o;
    logic [LW-1:0] line_first_o;
    logic [LW:0]   line_end_o;
    logic          pal_done_o, sync_err_o, off_done_o, dma_irq_o;
    logic [2:0]    dma_cond_o;

    fbfetch_seq #(.AW(AW), .LW(LW)) uut (.*);

    typedef struct packed {
        logic [31:0] addr;
        logic [12:0] len;
        logic        hdr;
    } req_t;

    req_t exp_q[$];
    int tests = 0, fails = 0, cyc = 0;
    int n_pal = 0, n_sync = 0, n_off = 0, n_c0 = 0, n_c1 = 0, n_c2 = 0, n_irq = 0;
    logic hold = 0, pal_pend = 0;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: drives ready and palette response, pops scoreboard, counts pulses
    always @(negedge clk) begin
        if (rst_n) begin
            pal_valid_i = pal_pend;
            pal_pend = 0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rd_ready_i = !hold && (lfsr[0] || lfsr[1]);
            if (rd_valid_o && rd_ready_i) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected read", rd_addr_o, 32'hFFFF_FFFF);
                end else begin
                    req_t e;
                    e = exp_q.pop_front();
                    check("R8 addr", rd_addr_o, e.addr);
                    check("R8 len", 32'(rd_len_o), 32'(e.len));
                    check("R2 hdr flag", 32'(rd_hdr_o), 32'(e.hdr));
                end
                if (rd_hdr_o) pal_pend = 1;
            end
            n_pal  += int'(pal_done_o);
            n_sync += int'(sync_err_o);
            n_off  += int'(off_done_o);
            n_c0   += int'(dma_cond_o[0]);
            n_c1   += int'(dma_cond_o[1]);
            n_c2   += int'(dma_cond_o[2]);
            n_irq  += int'(dma_irq_o);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog R8 actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic push_frame(input logic [31:0] top, input bit hdr, input logic [31:0] off,
                              input logic [12:0] stride, input int first, input int endl);
        req_t r;
        if (hdr) begin
            r.addr = top; r.len = 13'd512; r.hdr = 1'b1;
            exp_q.push_back(r);
        end
        for (int l = first; l < endl; l++) begin
            r.addr = top + off + 32'(l) * 32'(stride); r.len = stride; r.hdr = 1'b0;
            exp_q.push_back(r);
        end
    endtask

    task automatic strobe();
        @(negedge clk) frame_start_i = 1;
        @(negedge clk) frame_start_i = 0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 3000) begin @(negedge clk); n++; end
        if (n >= 3000) check("R8 drain", 32'(exp_q.size()), 32'd0);
        repeat (8) @(negedge clk);
    endtask

    task automatic set_en(input logic v);
        @(negedge clk) enable_i = v;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset rd_valid", 32'(rd_valid_o), 0);
        check("R10 reset active", 32'(active_o), 0);
        check("R7 reset cond", 32'(dma_cond_o), 0);

        // R1 buffer 0 bound bad
        bound_ok_i = 4'b1110;
        set_en(1);
        check("R1 cond2", n_c2, 1);
        check("R1 irq", n_irq, 1);
        check("R1 inactive", 32'(active_o), 0);
        set_en(0);
        check("R10 no off pulse when inactive", n_off, 0);
        // R1 dual buffer 1 bound bad
        dual_i = 1; bound_ok_i = 4'b0111;
        set_en(1);
        check("R1 dual cond2", n_c2, 2);
        set_en(0);

        // R2 buffer 1 bounds ignored when single; header load
        dual_i = 0; bound_ok_i = 4'b0011; pal_word_i = 16'h3000;
        push_frame(32'h1000, 1, 0, 0, 0, 0);
        @(negedge clk) enable_i = 1;
        drain();
        check("R2 pal_done", n_pal, 1);
        check("R1 active", 32'(active_o), 1);

        // R3 R5 R8 code 3
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); drain();
        check("R7 cond0", n_c0, 1);
        check("R4 bpp8", 32'(pix_bpp_o), 8);
        check("R8 stride", 32'(stride_o), 8);
        check("R2 pal once", n_pal, 1);

        // R4 R5 code 1 -> 2 bpp, short offset
        pal_word_i = 16'h1000;
        push_frame(32'h1000, 1, 32'h20, 13'd2, 0, 4);
        strobe(); drain();
        check("R4 bpp2", 32'(pix_bpp_o), 2);

        // R4 code 5, 12-bit when tft clear
        pal_word_i = 16'h5000; tft_i = 0;
        push_frame(32'h1000, 1, 32'h200, 13'd16, 0, 4);
        strobe(); drain();
        check("R4 bpp16", 32'(pix_bpp_o), 16);
        check("R4 12bit", 32'(pix_12bit_o), 1);

        // R3 R5 data-only mode uses held word, offset 0
        load_mode_i = 2; tft_i = 1;
        push_frame(32'h1000, 0, 0, 13'd16, 0, 4);
        strobe(); drain();
        check("R4 tft 16bit", 32'(pix_12bit_o), 0);
        check("R7 cond0 count", n_c0, 4);

        // R3 palette-only: nothing
        load_mode_i = 1;
        strobe(); repeat (20) @(negedge clk);
        check("R3 mode1 no frame", n_c0, 4);

        // R4 code 0 skipped
        load_mode_i = 0; pal_word_i = 16'h0000;
        push_frame(32'h1000, 1, 0, 0, 0, 0);
        strobe(); drain();
        check("R4 code0 skip", n_c0, 4);
        check("R4 code0 no sync", n_sync, 0);

        // R9 subpanel first line / line count
        pal_word_i = 16'h3000; sub_en_i = 1; sub_first_i = 1; sub_line_i = 10'd2;
        push_frame(32'h1000, 1, 32'h200, 13'd8, 2, 4);
        strobe(); drain();
        check("R9 first", 32'(line_first_o), 2);
        check("R9 end", 32'(line_end_o), 4);
        sub_first_i = 0; sub_line_i = 10'd1;
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 1);
        strobe(); drain();
        check("R9 count end", 32'(line_end_o), 1);
        sub_en_i = 0;

        // R11 strobe during fetch ignored
        hold = 1;
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); repeat (3) @(negedge clk);
        strobe(); hold = 0;
        drain(); repeat (10) @(negedge clk);
        check("R11 one frame", n_c0, 7);

        // R6 size boundary: exact fit passes, one byte less fails
        buf0_bot_i = 32'h121e;
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); drain();
        check("R6 fit", n_c0, 8);
        buf0_bot_i = 32'h121d;
        push_frame(32'h1000, 1, 0, 0, 0, 0);
        strobe(); drain();
        check("R6 sync", n_sync, 1);
        check("R6 inactive", 32'(active_o), 0);
        check("R6 no frame", n_c0, 8);
        buf0_bot_i = 32'h2000;
        set_en(0);
        check("R10 off after abort", n_off, 0);

        // R7 dual alternation
        dual_i = 1; bound_ok_i = 4'b1111;
        push_frame(32'h1000, 1, 0, 0, 0, 0);
        @(negedge clk) enable_i = 1;
        drain();
        check("R2 reload pal", n_pal, 2);
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); drain();
        push_frame(32'h8000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); drain();
        check("R7 cond1", n_c1, 1);
        push_frame(32'h1000, 1, 32'h200, 13'd8, 0, 4);
        strobe(); drain();
        check("R7 cond0 dual", n_c0, 10);

        // R10 disable mid-request, restart at buffer 0
        hold = 1;
        push_frame(32'h8000, 1, 0, 0, 0, 0);
        strobe(); repeat (4) @(negedge clk);
        check("R11 pending", 32'(rd_valid_o), 1);
        @(negedge clk) enable_i = 0;
        @(negedge clk);
        check("R10 request dropped", 32'(rd_valid_o), 0);
        exp_q.delete();
        hold = 0;
        repeat (3) @(negedge clk);
        check("R10 off pulse", n_off, 1);
        push_frame(32'h1000, 1, 0, 0, 0, 0);
        @(negedge clk) enable_i = 1;
        drain();
        check("R10 restart pal", n_pal, 3);
        check("R10 active", 32'(active_o), 1);
        check("R7 irq total", n_irq, n_c0 + n_c1 + n_c2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule